// File: doc/BRIEF.md
# Generation-Bit Work Queue Producer

The block takes work-request descriptors from an upstream requester and writes each one into the next free slot of a power-of-two ring that sits in a memory shared with a consumer. Every slot is sixteen 64-bit flits. Flits 1 to 14 carry the request's payload. Flit 0 carries two 32-bit header words. Flit 15 carries a validity marker. The consumer tells fresh entries from stale ones by comparing a generation bit with its own view of the lap. That bit is the inverse of the write pointer bit just above the slot index. It is written into flit 15 first and then into the second header word, which is the last memory write of the slot.

After the whole slot is in memory, the producer issues one doorbell write for its queue and advances its write pointer by one. The consumer reports its progress through a read-pointer input. While the ring holds as many outstanding slots as it has entries, the producer stops accepting requests. Both pointers are 32 bits wide and wrap freely.

Top module: `wq_producer`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_we` and `db_we` are 0, and `wr_ptr` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle until its doorbell, `req_ready` stays 0.
- R3: Every memory write for a request uses slot index `wr_ptr mod 2^SIZE_LOG2`. Payload flit k (1..14) carries `req_payload[(k-1)*64 +: 64]` with both lanes enabled (`mem_lane` = 2'b11).
- R4: The writes of a slot take one cycle each, with no gaps, in this order: flits 1 to 14 ascending, then flit 15, then flit 0 upper lane, then flit 0 lower lane. `mem_we` and `db_we` are never 1 together, and no write occurs without an accepted request.
- R5: The first header word goes to flit 0 bits 63:32 with `mem_lane` = 2'b10. Its layout is: opcode at bits 31:24, both bits 23:22 set, the flags starting at bit 8, and zeros elsewhere (the lower data half is 0).
- R6: The second header word goes to flit 0 bits 31:0 with `mem_lane` = 2'b01. Its layout is: generation bit at bit 31, tid starting at bit 8, length at bits 7:0, and zeros elsewhere.
- R7: The generation bit is the inverse of bit SIZE_LOG2 of the write pointer. Flit 15 holds it zero-extended to 64 bits, with both lanes enabled.
- R8: In the cycle after the second header word, `db_we` is 1 for one cycle with `db_wdata` = {1'b1, QUEUE_ID}. `wr_ptr` shows the incremented value in that same cycle.
- R9: The ring is full when `((wr_ptr - rd_ptr) >> SIZE_LOG2) != 0` and `wr_ptr != rd_ptr`. While it is full, `req_ready` is 0 and a held `req_valid` causes no write and no pointer change. Acceptance resumes in the cycle after `rd_ptr` advances.
- R10: On the second lap of the ring, slots are reused from index 0, and the generation bit in flit 15 and in the second header word flips to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | OP_W (8) | Work-request opcode |
| req_flags | input | FLAG_W (14) | Request flags |
| req_tid | input | TID_W (20) | Connection tag |
| req_len | input | 8 | Length in flits, placed in the header |
| req_payload | input | 14*64 | Payload flits 1..14, flit 1 in the low bits |
| rd_ptr | input | 32 | Consumer read pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_slot | output | SIZE_LOG2 (3) | Slot index |
| mem_flit | output | 4 | Flit index within slot |
| mem_lane | output | 2 | Lane enables: bit 1 = bits 63:32, bit 0 = bits 31:0 |
| mem_wdata | output | 64 | Write data |
| db_we | output | 1 | Doorbell write strobe |
| db_wdata | output | 32 | Doorbell value |
| wr_ptr | output | 32 | Producer write pointer |

## Verification
The occupancy assertion assumes that the consumer never moves `rd_ptr` past `wr_ptr` and never moves it backwards. Under that assumption, `wr_ptr - rd_ptr` never exceeds the ring depth. The stimulus changes `rd_ptr` only between slots, and only to values the producer has already passed. The ordering assertions assume the memory takes one write per cycle, with no back-pressure. The stimulus keeps `req_valid` asserted through full periods, so that held requests are seen to be refused.

// File: rtl/wq_pkg.sv
package wq_pkg;
  localparam int FLIT_W     = 64;
  localparam int WORD_W     = 32;
  localparam int SLOT_FLITS = 16;
  localparam int PAY_FLITS  = SLOT_FLITS - 2;
  localparam int FLIT_IDX_W = $clog2(SLOT_FLITS);
  localparam int PTR_W      = 32;

  localparam logic [1:0] LANE_BOTH = 2'b11;
  localparam logic [1:0] LANE_HI   = 2'b10;
  localparam logic [1:0] LANE_LO   = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAY,
    ST_GEN,
    ST_HDR_A,
    ST_HDR_B,
    ST_RING
  } seq_state_t;
endpackage

// File: rtl/wq_ring_ctrl.sv
module wq_ring_ctrl
  import wq_pkg::*;
#(
  parameter int SIZE_LOG2 = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic [PTR_W-1:0]     rd_ptr,
  output logic [PTR_W-1:0]     wr_ptr,
  output logic [SIZE_LOG2-1:0] slot,
  output logic                 gen,
  output logic                 full
);
  localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1) << SIZE_LOG2;

  logic [PTR_W-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst) wr_ptr <= '0;
    else if (step) wr_ptr <= wr_ptr + PTR_W'(1);
  end

  always_comb begin
    occ  = wr_ptr - rd_ptr;
    full = ((occ >> SIZE_LOG2) != '0) && (wr_ptr != rd_ptr);
    slot = wr_ptr[SIZE_LOG2-1:0];
    gen  = ~wr_ptr[SIZE_LOG2];
  end

  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) <= DEPTH);

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr != $past(wr_ptr)) |-> (wr_ptr == $past(wr_ptr) + PTR_W'(1)));
endmodule

// File: rtl/wq_hdr_fmt.sv
module wq_hdr_fmt
  import wq_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int FLAG_W = 14,
  parameter int TID_W  = 20,
  parameter int LEN_W  = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [FLAG_W-1:0] flags,
  input  logic [TID_W-1:0]  tid,
  input  logic [LEN_W-1:0]  len,
  input  logic              gen,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b
);
  localparam int OP_POS   = 24;
  localparam int EDGE_POS = 22;
  localparam int FLAG_POS = 8;
  localparam int TID_POS  = 8;
  localparam int GEN_POS  = 31;

  always_comb begin
    word_a = (WORD_W'(op) << OP_POS)
           | (WORD_W'(2'b11) << EDGE_POS)
           | (WORD_W'(flags) << FLAG_POS);
    word_b = (WORD_W'(gen) << GEN_POS)
           | (WORD_W'(tid) << TID_POS)
           | WORD_W'(len);
  end
endmodule

// File: rtl/wq_slot_seq.sv
module wq_slot_seq
  import wq_pkg::*;
#(
  parameter int          SIZE_LOG2 = 3,
  parameter int          OP_W      = 8,
  parameter int          FLAG_W    = 14,
  parameter int          TID_W     = 20,
  parameter int          LEN_W     = 8,
  parameter logic [30:0] QUEUE_ID  = 31'h5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [OP_W-1:0]         op,
  input  logic [FLAG_W-1:0]       flags,
  input  logic [TID_W-1:0]        tid,
  input  logic [LEN_W-1:0]        len,
  input  logic [PAY_FLITS*FLIT_W-1:0] payload,
  input  logic [SIZE_LOG2-1:0]    slot_in,
  input  logic                    gen_in,
  output logic                    busy,
  output logic                    step,
  output logic                    mem_we,
  output logic [SIZE_LOG2-1:0]    mem_slot,
  output logic [FLIT_IDX_W-1:0]   mem_flit,
  output logic [1:0]              mem_lane,
  output logic [FLIT_W-1:0]       mem_wdata,
  output logic                    db_we,
  output logic [WORD_W-1:0]       db_wdata
);
  localparam int                 PAY_W   = PAY_FLITS * FLIT_W;
  localparam logic [WORD_W-1:0]  DB_WORD = {1'b1, QUEUE_ID};
  localparam logic [FLIT_IDX_W-1:0] LAST_PAY = FLIT_IDX_W'(PAY_FLITS);
  localparam logic [FLIT_IDX_W-1:0] GEN_FLIT = FLIT_IDX_W'(SLOT_FLITS - 1);

  seq_state_t state;
  logic [FLIT_IDX_W-1:0] cnt;

  logic [OP_W-1:0]      op_q;
  logic [FLAG_W-1:0]    flags_q;
  logic [TID_W-1:0]     tid_q;
  logic [LEN_W-1:0]     len_q;
  logic [PAY_W-1:0]     pay_q;
  logic [SIZE_LOG2-1:0] slot_q;
  logic                 gen_q;
  logic [WORD_W-1:0]    word_a;
  logic [WORD_W-1:0]    word_b;

  wq_hdr_fmt #(
    .OP_W(OP_W), .FLAG_W(FLAG_W), .TID_W(TID_W), .LEN_W(LEN_W)
  ) hdr_i (
    .op(op_q), .flags(flags_q), .tid(tid_q), .len(len_q), .gen(gen_q),
    .word_a(word_a), .word_b(word_b)
  );

  assign busy = (state != ST_IDLE);
  assign step = (state == ST_RING);

  // request capture: data path, no reset needed
  always_ff @(posedge clk) begin
    if (start && state == ST_IDLE) begin
      op_q    <= op;
      flags_q <= flags;
      tid_q   <= tid;
      len_q   <= len;
      pay_q   <= payload;
      slot_q  <= slot_in;
      gen_q   <= gen_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      mem_we    <= 1'b0;
      mem_slot  <= '0;
      mem_flit  <= '0;
      mem_lane  <= '0;
      mem_wdata <= '0;
      db_we     <= 1'b0;
      db_wdata  <= '0;
    end else begin
      mem_we <= 1'b0;
      db_we  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_PAY;
            cnt   <= FLIT_IDX_W'(1);
          end
        end
        ST_PAY: begin
          mem_we    <= 1'b1;
          mem_slot  <= slot_q;
          mem_flit  <= cnt;
          mem_lane  <= LANE_BOTH;
          mem_wdata <= pay_q[(int'(cnt) - 1) * FLIT_W +: FLIT_W];
          if (cnt == LAST_PAY) state <= ST_GEN;
          else cnt <= cnt + FLIT_IDX_W'(1);
        end
        ST_GEN: begin
          mem_we    <= 1'b1;
          mem_slot  <= slot_q;
          mem_flit  <= GEN_FLIT;
          mem_lane  <= LANE_BOTH;
          mem_wdata <= FLIT_W'(gen_q);
          state     <= ST_HDR_A;
        end
        ST_HDR_A: begin
          mem_we    <= 1'b1;
          mem_slot  <= slot_q;
          mem_flit  <= '0;
          mem_lane  <= LANE_HI;
          mem_wdata <= {word_a, {WORD_W{1'b0}}};
          state     <= ST_HDR_B;
        end
        ST_HDR_B: begin
          mem_we    <= 1'b1;
          mem_slot  <= slot_q;
          mem_flit  <= '0;
          mem_lane  <= LANE_LO;
          mem_wdata <= {{WORD_W{1'b0}}, word_b};
          state     <= ST_RING;
        end
        ST_RING: begin
          db_we    <= 1'b1;
          db_wdata <= DB_WORD;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic hdra_wr, hdrb_wr, gen_wr;
  assign hdra_wr = mem_we && (mem_flit == '0) && (mem_lane == LANE_HI);
  assign hdrb_wr = mem_we && (mem_flit == '0) && (mem_lane == LANE_LO);
  assign gen_wr  = mem_we && (mem_flit == GEN_FLIT);

  // R4
  hdr_order_chk: assert property (@(posedge clk) disable iff (rst)
    hdrb_wr |-> $past(hdra_wr));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && db_we));

  // R7
  gen_twice_chk: assert property (@(posedge clk) disable iff (rst)
    hdrb_wr |-> ($past(gen_wr, 2) && (mem_wdata[31] == $past(mem_wdata[0], 2))));

  // R8
  db_after_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    db_we |-> $past(hdrb_wr));
endmodule

// File: rtl/wq_producer.sv
module wq_producer
  import wq_pkg::*;
#(
  parameter int          SIZE_LOG2 = 3,
  parameter int          OP_W      = 8,
  parameter int          FLAG_W    = 14,
  parameter int          TID_W     = 20,
  parameter int          LEN_W     = 8,
  parameter logic [30:0] QUEUE_ID  = 31'h5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [OP_W-1:0]             req_op,
  input  logic [FLAG_W-1:0]           req_flags,
  input  logic [TID_W-1:0]            req_tid,
  input  logic [LEN_W-1:0]            req_len,
  input  logic [PAY_FLITS*FLIT_W-1:0] req_payload,
  input  logic [PTR_W-1:0]            rd_ptr,
  output logic                        mem_we,
  output logic [SIZE_LOG2-1:0]        mem_slot,
  output logic [FLIT_IDX_W-1:0]       mem_flit,
  output logic [1:0]                  mem_lane,
  output logic [FLIT_W-1:0]           mem_wdata,
  output logic                        db_we,
  output logic [WORD_W-1:0]           db_wdata,
  output logic [PTR_W-1:0]            wr_ptr
);
  logic                 full;
  logic                 busy;
  logic                 step;
  logic                 gen;
  logic [SIZE_LOG2-1:0] slot;
  logic                 accept;

  assign req_ready = !busy && !full;
  assign accept    = req_valid && req_ready;

  wq_ring_ctrl #(.SIZE_LOG2(SIZE_LOG2)) ring_i (
    .clk(clk), .rst(rst), .step(step), .rd_ptr(rd_ptr),
    .wr_ptr(wr_ptr), .slot(slot), .gen(gen), .full(full)
  );

  wq_slot_seq #(
    .SIZE_LOG2(SIZE_LOG2), .OP_W(OP_W), .FLAG_W(FLAG_W),
    .TID_W(TID_W), .LEN_W(LEN_W), .QUEUE_ID(QUEUE_ID)
  ) seq_i (
    .clk(clk), .rst(rst), .start(accept),
    .op(req_op), .flags(req_flags), .tid(req_tid), .len(req_len),
    .payload(req_payload), .slot_in(slot), .gen_in(gen),
    .busy(busy), .step(step),
    .mem_we(mem_we), .mem_slot(mem_slot), .mem_flit(mem_flit),
    .mem_lane(mem_lane), .mem_wdata(mem_wdata),
    .db_we(db_we), .db_wdata(db_wdata)
  );

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
endmodule

// File: tb/wq_producer_tb.sv
module wq_producer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SL    = 3;
  localparam int NPAY  = 14;
  localparam logic [30:0] QID = 31'h3A5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0]  req_op = '0;
  logic [13:0] req_flags = '0;
  logic [19:0] req_tid = '0;
  logic [7:0]  req_len = '0;
  logic [NPAY*64-1:0] req_payload = '0;
  logic [31:0] rd_ptr = '0;
  logic mem_we;
  logic [SL-1:0] mem_slot;
  logic [3:0] mem_flit;
  logic [1:0] mem_lane;
  logic [63:0] mem_wdata;
  logic db_we;
  logic [31:0] db_wdata;
  logic [31:0] wr_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  wq_producer #(.SIZE_LOG2(SL), .QUEUE_ID(QID)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_flags(req_flags), .req_tid(req_tid),
    .req_len(req_len), .req_payload(req_payload), .rd_ptr(rd_ptr),
    .mem_we(mem_we), .mem_slot(mem_slot), .mem_flit(mem_flit),
    .mem_lane(mem_lane), .mem_wdata(mem_wdata), .db_we(db_we),
    .db_wdata(db_wdata), .wr_ptr(wr_ptr)
  );

  typedef struct {
    bit          is_db;
    int          slot;
    int          flit;
    logic [1:0]  lane;
    logic [63:0] data;
    logic [31:0] ptr;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  int exp_wptr = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] pay_flit(int n, int k);
    return {8'hC3 ^ 8'(n), 8'(k), 16'(n * 31 + k), 32'(n * 977 + k * 13 + 7)};
  endfunction

  // driver: present a request, wait for acceptance, queue expected writes
  task automatic send(input int n);
    logic gen;
    int   slot;
    logic [31:0] wa, wb;
    @(negedge clk);
    req_op    = 8'(8'h10 + n);
    req_flags = 14'(14'h2A5 ^ (n * 3));
    req_tid   = 20'(20'h1_2340 + n);
    req_len   = 8'(n + 3);
    for (int k = 1; k <= NPAY; k++) req_payload[(k-1)*64 +: 64] = pay_flit(n, k);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    slot = exp_wptr % (1 << SL);
    gen  = !((exp_wptr >> SL) & 1);
    wa = {req_op, 2'b11, req_flags, 8'h00};
    wb = {gen, 3'b000, req_tid, req_len};
    for (int k = 1; k <= NPAY; k++)
      sb.push_back('{1'b0, slot, k, 2'b11, pay_flit(n, k), 32'h0, "R3 R4 payload"});
    sb.push_back('{1'b0, slot, 15, 2'b11, 64'(gen),
                   32'h0, (exp_wptr >= (1 << SL)) ? "R10 gen flit" : "R7 gen flit"});
    sb.push_back('{1'b0, slot, 0, 2'b10, {wa, 32'h0}, 32'h0, "R5 header A"});
    sb.push_back('{1'b0, slot, 0, 2'b01, {32'h0, wb},
                   32'h0, (exp_wptr >= (1 << SL)) ? "R10 header B" : "R6 header B"});
    exp_wptr++;
    sb.push_back('{1'b1, 0, 0, 2'b00, {32'h0, 1'b1, QID}, 32'(exp_wptr), "R8 doorbell"});
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready low while slot written", 64'(req_ready), 64'd0);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare every produced write with the scoreboard head
  always @(negedge clk) begin
    if (!rst && (mem_we || db_we)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4 unexpected write", {mem_wdata[62:0], db_we}, 64'h0);
      end else begin
        item_t e;
        e = sb.pop_front();
        if (e.is_db) begin
          chk(db_we && !mem_we && db_wdata == e.data[31:0] && wr_ptr == e.ptr,
              e.tag, {wr_ptr, db_wdata}, {e.ptr, e.data[31:0]});
        end else begin
          chk(mem_we && !db_we && int'(mem_slot) == e.slot && int'(mem_flit) == e.flit
              && mem_lane == e.lane && mem_wdata == e.data,
              e.tag, mem_wdata, e.data);
          if (!(int'(mem_slot) == e.slot && int'(mem_flit) == e.flit && mem_lane == e.lane))
            $display("  (%s slot/flit/lane %0d/%0d/%b vs %0d/%0d/%b)", e.tag,
                     mem_slot, mem_flit, mem_lane, e.slot, e.flit, e.lane);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(mem_we == 1'b0 && db_we == 1'b0, "R1 strobes idle", {mem_we, db_we}, 64'd0);
    chk(wr_ptr == 32'd0, "R1 write pointer", 64'(wr_ptr), 64'd0);

    // first lap, back to back, until full
    for (int n = 0; n < (1 << SL); n++) send(n);
    drain();
    // R9 full with read pointer at 0
    chk(req_ready == 1'b0, "R9 ready low when full", 64'(req_ready), 64'd0);
    chk(wr_ptr == 32'd8, "R9 pointer at depth", 64'(wr_ptr), 64'd8);

    // hold a request while full: must be refused
    req_valid = 1'b1;
    repeat (30) @(negedge clk);
    chk(wr_ptr == 32'd8, "R9 held request ignored", 64'(wr_ptr), 64'd8);
    chk(req_ready == 1'b0, "R9 still refused", 64'(req_ready), 64'd0);
    req_valid = 1'b0;

    rd_ptr = 32'd4;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 resumes after read advance", 64'(req_ready), 64'd1);

    // second lap: generation bit flips
    for (int n = 8; n < 12; n++) send(n);
    drain();
    chk(req_ready == 1'b0, "R9 full again on second lap", 64'(req_ready), 64'd0);
    chk(wr_ptr == 32'd12, "R10 pointer after second lap", 64'(wr_ptr), 64'd12);

    rd_ptr = 32'd12;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 empty ring accepts", 64'(req_ready), 64'd1);
    chk(sb.size() == 0, "R4 all expected writes seen", 64'(sb.size()), 64'd0);
    summary();
  end
endmodule